// File: doc/BRIEF.md
# Burst address sequence generator

This block produces the address for every access of a four-beat memory burst. A burst opens when one of two active-low address strobes is sampled with the enables valid. The external address is then captured and driven out unchanged as beat 0. Each later request on the active-low step input moves the burst to the next beat. Only the two low address bits take part in the beat ordering. The upper bits stay fixed and never receive a carry.

A static order-select input picks the ordering. When it is high, the low bits of beat n are the starting bits XOR n (interleaved). When it is low, the low bits are the starting bits plus n, modulo four (linear). The processor-side strobe is masked by the master enable. The controller-side strobe is not masked. A strobe that is honoured while the enables are not valid deselects the block: the address holds and the burst stops.

Control is a two-state machine. In ST_IDLE no burst is open; the block leaves reset in this state. In ST_BURST a burst is open. The transitions are:
- LOAD: any state to ST_BURST.
- STEP: ST_BURST to ST_BURST, advancing the beat.
- HOLD: the state is kept.
- DESEL: any state to ST_IDLE.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low and after its release, the state is ST_IDLE and addr_out is all zeros.
- R2: When cpu_strobe_n is low and en_master and en_group are both high, the next edge loads addr_in: addr_out equals addr_in and the beat index is 0. step_n is ignored on that edge.
- R3: When ctl_strobe_n is low and en_master and en_group are both high, the next edge loads addr_in in the same way as R2.
- R4: When en_master is low, a low cpu_strobe_n is treated as high. If ctl_strobe_n is high and step_n is low in an open burst, the beat advances.
- R5: When a strobe is honoured but the enables are not valid, the edge is a DESEL. This happens when ctl_strobe_n is low with either enable low, or when cpu_strobe_n is low with en_master high and en_group low. addr_out holds and the state becomes ST_IDLE.
- R6: In ST_BURST, with no strobe honoured and step_n low, the beat index n increments by one on the edge.
- R7: With no strobe honoured and step_n high, addr_out holds its value.
- R8: With order_sel high (interleaved), addr_out[1:0] equals start[1:0] XOR n.
- R9: With order_sel low (linear), addr_out[1:0] equals (start[1:0] + n) mod 4.
- R10: addr_out above bit 1 stays equal to the loaded address for the whole burst. After four steps the low bits return to the starting value.
- R11: In ST_IDLE, step_n low has no effect on addr_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External start address |
| cpu_strobe_n | input | 1 | Processor-side load strobe, active low, masked by en_master |
| ctl_strobe_n | input | 1 | Controller-side load strobe, active low |
| step_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | 1 selects interleaved order, 0 selects linear order |
| en_master | input | 1 | Master enable, active high |
| en_group | input | 1 | Remaining chip enables, valid when high |
| addr_out | output | ADDR_W | Current burst address |

## Verification
The bench covers both orderings, every starting value of the low bits, and both strobes. It walks five beats so the wrap back to the start is visible. A design that carried into the upper bits, or that swapped the XOR and add orderings, would break the beat sequence.

During a processor-strobe load, the step input is held low. A design that advanced on that edge would show beat 1 instead of beat 0.

The masked processor strobe must still let a step through. A design that did not mask it would reload or deselect instead of advancing. The bench also runs deselect followed by a step with no burst open. A design that kept counting there would move an address that should stay fixed.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_STEP  = 2'd2,
        CMD_DESEL = 2'd3
    } burst_cmd_e;

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_strobe_n,
    input  logic       ctl_strobe_n,
    input  logic       step_n,
    input  logic       en_master,
    input  logic       en_group,
    output burst_cmd_e cmd
);

    logic cpu_taken;
    logic ctl_taken;
    logic enables_ok;

    always_comb begin
        cpu_taken  = !cpu_strobe_n && en_master;
        ctl_taken  = !ctl_strobe_n;
        enables_ok = en_master && en_group;
        if (cpu_taken || ctl_taken) begin
            cmd = enables_ok ? CMD_LOAD : CMD_DESEL;
        end else if (!step_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // R2
    cpu_load_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && en_master && en_group) |-> (cmd == CMD_LOAD));

    // R4
    masked_cpu_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !en_master && ctl_strobe_n && !step_n) |-> (cmd == CMD_STEP));

    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe_n && ctl_strobe_n && step_n) |-> (cmd == CMD_HOLD));

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q,
    output burst_state_e      state_q
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    burst_state_e      state_d;
    logic [ADDR_W-1:0] base_d;
    logic [BEAT_W-1:0] beat_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        unique case (cmd)
            CMD_LOAD: begin
                state_d = ST_BURST;
                base_d  = addr_in;
                beat_d  = '0;
            end
            CMD_STEP: begin
                if (state_q == ST_BURST) begin
                    beat_d = beat_q + BEAT_ONE;
                end
            end
            CMD_DESEL: begin
                state_d = ST_IDLE;
            end
            CMD_HOLD: begin
                state_d = state_q;
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            base_q <= base_d;
            beat_q <= beat_d;
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (base_q == $past(addr_in)) && (beat_q == '0) && (state_q == ST_BURST));

    // R6
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && state_q == ST_BURST) |=> (beat_q == $past(beat_q) + BEAT_ONE));

    // R10
    base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD) |=> $stable(base_q));

    // R5
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DESEL) |=> (state_q == ST_IDLE) && $stable(beat_q));

    // R11
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && state_q == ST_IDLE) |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int BEAT_W     = 2,
    parameter bit HAS_LINEAR = 1'b1
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] xor_low;

    assign xor_low = start ^ beat;

    generate
        if (HAS_LINEAR) begin : g_both
            logic [BEAT_W-1:0] add_low;
            assign add_low = start + beat;
            assign low     = order_sel ? xor_low : add_low;
        end else begin : g_xor_only
            logic unused_sel;
            assign unused_sel = order_sel;
            assign low        = xor_low;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic              en_master,
    input  logic              en_group,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int BEAT_W = 2;

    burst_cmd_e        cmd;
    burst_state_e      state_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_bits;

    burst_load_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .en_master    (en_master),
        .en_group     (en_group),
        .cmd          (cmd)
    );

    burst_beat_fsm #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q),
        .state_q (state_q)
    );

    burst_order_map #(
        .BEAT_W     (BEAT_W),
        .HAS_LINEAR (1'b1)
    ) u_map (
        .start     (base_q[BEAT_W-1:0]),
        .beat      (beat_q),
        .order_sel (order_sel),
        .low       (low_bits)
    );

    assign addr_out = {base_q[ADDR_W-1:BEAT_W], low_bits};

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && beat_q == '0) |-> (addr_out == base_q));

    // R10
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_out[ADDR_W-1:BEAT_W] == base_q[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_in = 8'h00;
    logic       cpu_strobe_n = 1'b1;
    logic       ctl_strobe_n = 1'b1;
    logic       step_n = 1'b1;
    logic       order_sel = 1'b1;
    logic       en_master = 1'b1;
    logic       en_group = 1'b1;
    logic [7:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(8)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_in      (addr_in),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .order_sel    (order_sel),
        .en_master    (en_master),
        .en_group     (en_group),
        .addr_out     (addr_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] st, input int n, input logic mode);
        logic [1:0] lo;
        lo = mode ? (st[1:0] ^ 2'(n)) : 2'(int'(st[1:0]) + n);
        return {st[7:2], lo};
    endfunction

    task automatic quiet();
        cpu_strobe_n = 1'b1;
        ctl_strobe_n = 1'b1;
        en_master    = 1'b1;
        en_group     = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        chk("R1 in reset", addr_out, 8'h00);
        rst_n = 1'b1;
        step_n = 1'b0;
        tick();
        chk("R1 after release, R11 idle step", addr_out, 8'h00);

        // R2 R3 R8 R9 R10: sweep order, strobe and every start
        for (int mode = 0; mode < 2; mode++) begin
            for (int via = 0; via < 2; via++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [7:0] st;
                    st = {6'(13 * s + 7 * mode + 3 * via + 1), 2'(s)};
                    order_sel = mode[0];
                    addr_in   = st;
                    step_n    = 1'b0;
                    if (via == 0) cpu_strobe_n = 1'b0;
                    else          ctl_strobe_n = 1'b0;
                    tick();
                    chk(via == 0 ? "R2 load ignores step" : "R3 controller load",
                        addr_out, st);
                    quiet();
                    addr_in = ~st;
                    for (int b = 1; b <= 4; b++) begin
                        tick();
                        chk(mode == 1 ? "R8 interleaved beat, R10" : "R9 linear beat, R10",
                            addr_out, model(st, b % 4, mode[0]));
                    end
                    step_n = 1'b1;
                    tick();
                    chk("R7 hold", addr_out, st);
                end
            end
        end

        // R4 masked processor strobe lets a step through
        order_sel = 1'b0;
        addr_in = 8'hA5;
        cpu_strobe_n = 1'b0;
        step_n = 1'b1;
        tick();
        chk("R2 load A5", addr_out, 8'hA5);
        addr_in = 8'h3C;
        en_master = 1'b0;
        step_n = 1'b0;
        tick();
        chk("R4 masked strobe steps", addr_out, 8'hA6);

        // R5 controller strobe with master low deselects
        ctl_strobe_n = 1'b0;
        tick();
        chk("R5 desel master low", addr_out, 8'hA6);
        quiet();
        tick();
        chk("R11 idle step ignored", addr_out, 8'hA6);

        // R5 processor strobe with group enable low
        cpu_strobe_n = 1'b0;
        tick();
        chk("R2 reload", addr_out, 8'h3C);
        en_group = 1'b0;
        tick();
        chk("R5 desel group low", addr_out, 8'h3C);
        quiet();
        tick();
        chk("R11 idle after desel", addr_out, 8'h3C);

        // R5 controller strobe with group enable low
        ctl_strobe_n = 1'b0;
        tick();
        chk("R3 reload", addr_out, 8'h3C);
        quiet();
        tick();
        chk("R6 step", addr_out, 8'h3D);
        ctl_strobe_n = 1'b0;
        en_group = 1'b0;
        tick();
        chk("R5 ctl desel", addr_out, 8'h3D);
        quiet();
        tick();
        chk("R11 idle", addr_out, 8'h3D);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule